// File: doc/BRIEF.md
# FIFO Threshold Offset Register File

This block keeps the two threshold values that a FIFO's flag logic compares against its fill level: the empty-side offset, which sets how close to empty the almost-empty flag rises, and the full-side offset, which does the same for almost-full. Both registers come out of reset holding a value chosen from the FIFO depth. They are presented continuously to the flag logic.

A host reaches both registers through one active-low select strobe. While the strobe is held low, each access goes to the empty-side offset first and to the full-side offset second. The access is either a write qualified by the active-low write enable, or a readback qualified by the active-low read enable. Accesses after that keep alternating between the two registers. Releasing the strobe points the sequence back at the empty-side register. Readback places the selected value on a registered bus and is honoured only in standard mode. When the mode input selects first-word-fall-through, a readback request is ignored. All activity is on one clock with a synchronous active-high reset.

Top module: `fifo_ofs_regfile`

## Requirements
- R1: During and after reset, both offsets equal the depth default: 31 for DEPTH at most 256, 63 for DEPTH at most 512, and 127 otherwise (127 at the default DEPTH of 1024). The readback bus is 0 and the access pointer selects the empty-side register.
- R2: A clock edge that samples `sel_n`=0 and `wr_n`=0 while the pointer is on the empty side loads `wdata` into `empty_ofs` and leaves `full_ofs` unchanged.
- R3: The next such write loads `full_ofs` and leaves `empty_ofs` unchanged. A third write in the same strobe window wraps back to `empty_ofs`.
- R4: A clock edge that samples `sel_n`=0, `wr_n`=1, `rd_n`=0 and `fwft`=0 puts the register under the pointer on `rb_data`: the empty side first, then the full side, alternating.
- R5: With `fwft`=1, a readback request leaves `rb_data` unchanged and does not advance the pointer.
- R6: Any edge that samples `sel_n`=1 returns the pointer to the empty side.
- R7: With `sel_n`=1, `wr_n`=0 changes neither offset, and `rd_n`=0 leaves `rb_data` unchanged.
- R8: When `sel_n`, `wr_n` and `rd_n` are all 0, the write takes place and readback does not. The pointer advances once.
- R9: Edges with `sel_n`=0 but `wr_n`=1 and `rd_n`=1 change no register and hold the pointer.
- R10: `rb_data` keeps its last value on every edge that performs no readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select strobe for the offset registers |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low read enable |
| fwft | input | 1 | 1 = first-word-fall-through mode, 0 = standard mode |
| wdata | input | OFS_W | Value written to the selected offset |
| empty_ofs | output | OFS_W | Empty-side threshold offset to the flag logic |
| full_ofs | output | OFS_W | Full-side threshold offset to the flag logic |
| rb_data | output | OFS_W | Registered readback value |

## Verification
The hardest state to reach is a pointer on the full side at the moment the mode or the strobe changes. There is no port that shows the pointer. The stimulus therefore builds that state with a single write or readback inside a held strobe window, and then applies the case under test: a refused readback in fall-through mode, a combined write and read, idle cycles, or a strobe release. The next ordinary access then reveals which register the pointer selected. Each readback result is queued when it is requested and compared on the following half cycle.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

  typedef enum logic {
    SIDE_EMPTY = 1'b0,
    SIDE_FULL  = 1'b1
  } ofs_side_e;

  // depth-dependent reset value of both offsets
  function automatic int unsigned ofs_default(input int unsigned depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

endpackage

// File: rtl/fifo_ofs_seq.sv
module fifo_ofs_seq
  import fifo_ofs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sel_n,
  input  logic      wr_n,
  input  logic      rd_n,
  input  logic      fwft,
  output logic      wr_go,
  output logic      rd_go,
  output ofs_side_e side
);

  // write wins over readback; readback refused in fall-through mode
  always_comb begin
    wr_go = !sel_n && !wr_n;
    rd_go = !sel_n && wr_n && !rd_n && !fwft;
  end

  always_ff @(posedge clk) begin
    if (rst || sel_n) begin
      side <= SIDE_EMPTY;
    end else if (wr_go || rd_go) begin
      side <= (side == SIDE_EMPTY) ? SIDE_FULL : SIDE_EMPTY;
    end
  end

endmodule

// File: rtl/fifo_ofs_regs.sv
module fifo_ofs_regs
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter logic [OFS_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  ofs_side_e        side,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] empty_q,
  output logic [OFS_W-1:0] full_q
);

  logic [OFS_W-1:0] ofs_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (rst) begin
        ofs_q[g] <= RST_VAL;
      end else if (wr_go && (int'(side) == g)) begin
        ofs_q[g] <= wdata;
      end
    end
  end

  assign empty_q = ofs_q[int'(SIDE_EMPTY)];
  assign full_q  = ofs_q[int'(SIDE_FULL)];

endmodule

// File: rtl/fifo_ofs_rbk.sv
module fifo_ofs_rbk
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  ofs_side_e        side,
  input  logic [OFS_W-1:0] empty_q,
  input  logic [OFS_W-1:0] full_q,
  output logic [OFS_W-1:0] rb_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q <= '0;
    end else if (rd_go) begin
      rb_q <= (side == SIDE_FULL) ? full_q : empty_q;
    end
  end

endmodule

// File: rtl/fifo_ofs_regfile.sv
module fifo_ofs_regfile
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             fwft,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [OFS_W-1:0] rb_data
);

  localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(ofs_default(DEPTH));

  logic      wr_go;
  logic      rd_go;
  ofs_side_e side;

  fifo_ofs_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .rd_n  (rd_n),
    .fwft  (fwft),
    .wr_go (wr_go),
    .rd_go (rd_go),
    .side  (side)
  );

  fifo_ofs_regs #(
    .OFS_W   (OFS_W),
    .RST_VAL (DEF_OFS)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (wr_go),
    .side    (side),
    .wdata   (wdata),
    .empty_q (empty_ofs),
    .full_q  (full_ofs)
  );

  fifo_ofs_rbk #(
    .OFS_W (OFS_W)
  ) u_rbk (
    .clk     (clk),
    .rst     (rst),
    .rd_go   (rd_go),
    .side    (side),
    .empty_q (empty_ofs),
    .full_q  (full_ofs),
    .rb_q    (rb_data)
  );

endmodule

// File: rtl/fifo_ofs_regfile_chk.sv
module fifo_ofs_regfile_chk #(
  parameter int unsigned OFS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             wr_n,
  input logic             rd_n,
  input logic             fwft,
  input logic [OFS_W-1:0] wdata,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input logic [OFS_W-1:0] rb_data,
  input logic             on_full
);

  // R2
  a_r2_empty_load: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && !on_full) |=> (empty_ofs == $past(wdata)) && $stable(full_ofs));

  // R3
  a_r3_full_load: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && on_full) |=> (full_ofs == $past(wdata)) && $stable(empty_ofs));

  // R4
  a_r4_readback: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && wr_n && !rd_n && !fwft) |=>
      (rb_data == ($past(on_full) ? $past(full_ofs) : $past(empty_ofs))));

  // R5
  a_r5_fwft_refused: assert property (@(posedge clk) disable iff (rst)
    (fwft && wr_n) |=> $stable(rb_data) && ($stable(on_full) || $past(sel_n)));

  // R6
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !on_full);

  // R7
  a_r7_no_load: assert property (@(posedge clk) disable iff (rst)
    (sel_n || wr_n) |=> $stable(empty_ofs) && $stable(full_ofs));

  // R8
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && !rd_n) |=> $stable(rb_data) && (on_full != $past(on_full)));

  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && wr_n && rd_n) |=> $stable(on_full) && $stable(rb_data));

endmodule

bind fifo_ofs_regfile fifo_ofs_regfile_chk #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_n     (sel_n),
  .wr_n      (wr_n),
  .rd_n      (rd_n),
  .fwft      (fwft),
  .wdata     (wdata),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .rb_data   (rb_data),
  .on_full   (side == fifo_ofs_pkg::SIDE_FULL)
);

// File: tb/test_fifo_ofs_regfile.sv
module test_fifo_ofs_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 12;
  localparam int DEPTH = 1024;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sel_n = 1'b1;
  logic             wr_n = 1'b1;
  logic             rd_n = 1'b1;
  logic             fwft = 1'b0;
  logic [OFS_W-1:0] wdata = '0;
  logic [OFS_W-1:0] empty_ofs;
  logic [OFS_W-1:0] full_ofs;
  logic [OFS_W-1:0] rb_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [OFS_W-1:0] m_emp;
  logic [OFS_W-1:0] m_full;
  logic [OFS_W-1:0] m_rb;
  bit               m_on_full;

  logic [OFS_W-1:0] q_val [$];
  string            q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_ofs_regfile #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_fifo_ofs_regfile (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .fwft      (fwft),
    .wdata     (wdata),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rb_data   (rb_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [OFS_W-1:0] act, input logic [OFS_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares queued readback results
  always @(negedge clk) begin
    while (q_val.size() > 0) begin
      chk(q_tag[0], "rb_data", rb_data, q_val[0]);
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // driver: one access edge, model update, then offset checks
  task automatic access(input string tag, input bit s_n, input bit w_n,
                        input bit r_n, input logic [OFS_W-1:0] d);
    bit do_wr;
    bit do_rd;
    @(negedge clk);
    sel_n = s_n; wr_n = w_n; rd_n = r_n; wdata = d;
    @(posedge clk);
    do_wr = !s_n && !w_n;
    do_rd = !s_n && w_n && !r_n && !fwft;
    if (do_rd) begin
      m_rb = m_on_full ? m_full : m_emp;
      q_val.push_back(m_rb);
      q_tag.push_back(tag);
    end
    if (do_wr) begin
      if (m_on_full) m_full = d;
      else           m_emp = d;
    end
    if (s_n)                m_on_full = 1'b0;
    else if (do_wr || do_rd) m_on_full = !m_on_full;
    #1;
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk(tag, "empty_ofs", empty_ofs, m_emp);
    chk(tag, "full_ofs", full_ofs, m_full);
    if (!do_rd) chk(tag, "rb_data held (R10)", rb_data, m_rb);
  endtask

  initial begin
    m_emp = 12'd127; m_full = 12'd127; m_rb = '0; m_on_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with defaults for DEPTH 1024
    chk("R1", "empty_ofs", empty_ofs, 12'd127);
    chk("R1", "full_ofs", full_ofs, 12'd127);
    chk("R1", "rb_data", rb_data, 12'd0);
    rst = 1'b0;

    // R4: readback of defaults, empty side then full side
    access("R4", 1'b0, 1'b1, 1'b0, '0);
    access("R4", 1'b0, 1'b1, 1'b0, '0);
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R2 / R3: write sequence and wrap
    access("R2", 1'b0, 1'b0, 1'b1, 12'h00A);
    access("R3", 1'b0, 1'b0, 1'b1, 12'hABC);
    access("R3", 1'b0, 1'b0, 1'b1, 12'h123);
    // R6: release mid-sequence (pointer on full) returns to empty side
    access("R6", 1'b1, 1'b1, 1'b1, '0);
    access("R6", 1'b0, 1'b0, 1'b1, 12'h055);
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R4: readback of written values, alternating
    access("R4", 1'b0, 1'b1, 1'b0, '0);
    access("R4", 1'b0, 1'b1, 1'b0, '0);
    access("R4", 1'b0, 1'b1, 1'b0, '0);
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R8: combined write and read, then readback from full side
    access("R8", 1'b0, 1'b0, 1'b0, 12'h777);
    access("R8", 1'b0, 1'b1, 1'b0, '0);
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R5: refused readback in fall-through mode, pointer not advanced
    access("R5", 1'b0, 1'b1, 1'b0, '0);   // pointer to full, rb = empty side
    @(negedge clk); fwft = 1'b1;
    access("R5", 1'b0, 1'b1, 1'b0, '0);
    access("R5", 1'b0, 1'b1, 1'b0, '0);
    access("R5", 1'b0, 1'b0, 1'b1, 12'h3C3); // must land on full side
    @(negedge clk); fwft = 1'b0;
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R7: strobe released, enables have no effect
    access("R7", 1'b1, 1'b0, 1'b1, 12'hFFF);
    access("R7", 1'b1, 1'b1, 1'b0, '0);
    access("R7", 1'b1, 1'b0, 1'b0, 12'h001);

    // R9: idle cycles inside strobe window hold the pointer
    access("R9", 1'b0, 1'b0, 1'b1, 12'h0F0);  // pointer to full
    access("R9", 1'b0, 1'b1, 1'b1, '0);
    access("R9", 1'b0, 1'b1, 1'b1, '0);
    access("R9", 1'b0, 1'b0, 1'b1, 12'h0E1);  // lands on full side
    access("R9", 1'b0, 1'b1, 1'b0, '0);       // back to empty side
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    // R1: reset restores defaults and pointer
    access("R1", 1'b0, 1'b0, 1'b1, 12'h200);  // pointer to full
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_emp = 12'd127; m_full = 12'd127; m_rb = '0; m_on_full = 1'b0;
    chk("R1", "empty_ofs after reset", empty_ofs, 12'd127);
    chk("R1", "full_ofs after reset", full_ofs, 12'd127);
    chk("R1", "rb_data after reset", rb_data, 12'd0);
    access("R1", 1'b0, 1'b0, 1'b1, 12'h444);  // must land on empty side
    access("R6", 1'b1, 1'b1, 1'b1, '0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule